// File: doc/BRIEF.md
# Denormal flush and substitution unit

This unit wraps a single-precision floating-point datapath and decides what to do with tiny (subnormal) values. The surrounding arithmetic supplies the operands, a possible fused multiply-add intermediate product and the pre-rounded result. Three mode bits and a 2-bit rounding mode select the handling:

- **Full IEEE mode.** Tiny values are left untouched, and each one raises an "unimplemented" indication.
- **Flush modes.** Tiny values are replaced by substitutes. Which values are replaced, and by what, depends on the mode bits and the rounding mode.

The three mode bits are:

- **`mode_fo`** flushes tiny operands and tiny results.
- **`mode_fs`** does the same and also flushes the tiny intermediate of a fused operation. A fused operation then matches a separate multiply followed by an add.
- **`mode_fn`** replaces a tiny result with whichever of zero or the smallest normal magnitude is nearer.

All outputs are registered. They appear one cycle after an input valid pulse, together with an output valid. A sticky bit records whether the most recent operation raised the unimplemented indication.

Top module: `dnf_unit`

## Requirements
- R1: A value is tiny when its 8-bit biased exponent field (bits 30:23) is 0 and its 23-bit fraction (bits 22:0) is nonzero. Zeros, normals, infinities and NaNs pass through unchanged in every mode, with no flag raised.
- R2: When `mode_fs`, `mode_fo` and `mode_fn` are all 0, no value is altered. Any tiny operand or tiny result raises `unimpl` and sets `sticky_e`.
- R3: When `mode_fs` or `mode_fo` is 1, each tiny operand is replaced by a zero of the same sign (bit 31 kept, bits 30:0 cleared) and raises no `unimpl`.
- R4: The fused intermediate `prod_in` is considered only when `fused_in` is 1. A tiny intermediate is replaced by a signed zero when `mode_fs` is 1. Otherwise it passes unchanged and raises `unimpl`. When `fused_in` is 0, `prod_in` passes unchanged and raises nothing.
- R5: When `mode_fn` is 1, a tiny result becomes the smallest normal magnitude (0x00800000 with the original sign) when its fraction is at least 0x400000; an exact tie resolves to the smallest normal. Otherwise it becomes a signed zero. The rounding mode is ignored in this case.
- R6: When `mode_fn` is 0 and `mode_fs` or `mode_fo` is 1, a tiny result is replaced according to `rnd_mode` (0 nearest, 1 toward zero, 2 toward plus, 3 toward minus):
  - Under toward plus, a positive tiny result becomes 0x00800000 and a negative one becomes 0x80000000.
  - Under toward minus, a negative tiny result becomes 0x80800000 and a positive one becomes 0x00000000.
  - Under nearest or toward zero, the result becomes a signed zero.
- R7: A substituted result keeps the sign of the original and pulses `flag_underflow` and `flag_inexact` with the output. It raises no `unimpl` of its own.
- R8: `sticky_e` takes the value of the `unimpl` indication of each completed operation, so an operation without one clears it. It holds its value while no operation is presented.
- R9: Outputs update on the first clock edge after `in_valid` is sampled high, with a one-cycle `out_valid` pulse. Data outputs hold between operations, while `flag_underflow`, `flag_inexact` and `unimpl` read 0 in cycles without `out_valid`.
- R10: After a synchronous active-low reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| mode_fs | input | 1 | Flush operands, results and fused intermediates |
| mode_fo | input | 1 | Flush operands and results |
| mode_fn | input | 1 | Replace tiny results with the nearer of zero or smallest normal |
| rnd_mode | input | 2 | Rounding mode: 0 nearest, 1 toward zero, 2 toward plus, 3 toward minus |
| ops_in | input | 96 | Three operands; operand k sits at bits 32k+31:32k |
| fused_in | input | 1 | The operation is a fused multiply-add |
| prod_in | input | 32 | Fused intermediate product |
| result_in | input | 32 | Pre-rounded result |
| out_valid | output | 1 | Registered outputs are new this cycle |
| ops_out | output | 96 | Operands after substitution |
| prod_out | output | 32 | Intermediate after substitution |
| result_out | output | 32 | Result after substitution |
| flag_underflow | output | 1 | Result was substituted |
| flag_inexact | output | 1 | Result was substituted |
| unimpl | output | 1 | Unimplemented indication for this operation |
| sticky_e | output | 1 | Unimplemented status of the last operation |

## Verification
The result substitution path and the operand unimplemented path can both act on one operation. With only `mode_fn` set, a tiny operand is not flushed and raises `unimpl`, while a tiny result in the same operation is still replaced. A table vector provokes this by presenting a tiny operand together with a tiny result above the halfway point. The check then expects the operand unchanged, the result replaced by the signed smallest normal, and `flag_underflow`, `unimpl` and `sticky_e` all high in the same output cycle.

// File: rtl/dnf_pkg.sv
// Shared definitions for the denormal flush unit.
// Assumes IEEE-754 binary32 layout: sign, biased exponent, fraction.
package dnf_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_UP   = 2'd2,
        RND_DOWN = 2'd3
    } rnd_e;
endpackage

// File: rtl/dnf_classify.sv
// Flags a value as tiny: exponent field all zero, fraction nonzero.
// Assumes the caller passes only the exponent and fraction fields.
module dnf_classify #(
    parameter int EXP_W  = dnf_pkg::EXP_W,
    parameter int FRAC_W = dnf_pkg::FRAC_W
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              tiny_o
);
    // Tiny detection: zero exponent with a nonzero fraction.
    always_comb tiny_o = (exp_i == '0) && (frac_i != '0);
endmodule

// File: rtl/dnf_operand_flush.sv
// Replaces a tiny input value by a signed zero when flushing is enabled.
// Otherwise it reports the tiny value as unimplemented.
// Assumes active_i gates whether the value takes part in the operation at all.
module dnf_operand_flush #(
    parameter int EXP_W  = dnf_pkg::EXP_W,
    parameter int FRAC_W = dnf_pkg::FRAC_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] value_i,
    input  logic              active_i,
    input  logic              flush_i,
    output logic [WORD_W-1:0] value_o,
    output logic              unimpl_o
);
    logic tiny;

    dnf_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .exp_i  (value_i[WORD_W-2:FRAC_W]),
        .frac_i (value_i[FRAC_W-1:0]),
        .tiny_o (tiny)
    );

    // Substitute a signed zero or flag the tiny value as unhandled.
    always_comb begin
        value_o  = value_i;
        unimpl_o = 1'b0;
        if (tiny && active_i) begin
            if (flush_i) value_o  = {value_i[WORD_W-1], {(WORD_W-1){1'b0}}};
            else         unimpl_o = 1'b1;
        end
    end
endmodule

// File: rtl/dnf_result_subst.sv
// Chooses the replacement for a tiny result: either the nearer of zero and the
// smallest normal, or a value picked by the directed rounding mode.
// Assumes nearest_i takes priority over the rounding mode.
module dnf_result_subst #(
    parameter int EXP_W  = dnf_pkg::EXP_W,
    parameter int FRAC_W = dnf_pkg::FRAC_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] value_i,
    input  logic              flush_i,
    input  logic              nearest_i,
    input  dnf_pkg::rnd_e     rnd_i,
    output logic [WORD_W-1:0] value_o,
    output logic              subst_o,
    output logic              unimpl_o
);
    localparam logic [WORD_W-2:0] MIN_MAG = {{(EXP_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

    logic tiny;
    logic sign;
    logic at_half;
    logic pick_min;

    dnf_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .exp_i  (value_i[WORD_W-2:FRAC_W]),
        .frac_i (value_i[FRAC_W-1:0]),
        .tiny_o (tiny)
    );

    // Magnitude is at least half the smallest normal when the top fraction bit is set.
    always_comb begin
        sign    = value_i[WORD_W-1];
        at_half = value_i[FRAC_W-1];
    end

    // Decide between signed zero and signed smallest normal.
    always_comb begin
        if (nearest_i) pick_min = at_half;
        else           pick_min = ((rnd_i == dnf_pkg::RND_UP)   && !sign) ||
                                  ((rnd_i == dnf_pkg::RND_DOWN) &&  sign);
    end

    // Apply the substitution or report the tiny result as unhandled.
    always_comb begin
        value_o  = value_i;
        subst_o  = 1'b0;
        unimpl_o = 1'b0;
        if (tiny) begin
            if (flush_i || nearest_i) begin
                subst_o = 1'b1;
                value_o = {sign, pick_min ? MIN_MAG : {(WORD_W-1){1'b0}}};
            end else begin
                unimpl_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dnf_unit.sv
// Denormal flush and substitution unit, top level.
// Flushes tiny operands, fused intermediates and results according to three
// mode bits and the rounding mode, then registers everything for one cycle.
// Assumes in_valid is a single-cycle pulse per operation.
module dnf_unit #(
    parameter int EXP_W   = dnf_pkg::EXP_W,
    parameter int FRAC_W  = dnf_pkg::FRAC_W,
    parameter int NUM_OPS = 3,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      mode_fs,
    input  logic                      mode_fo,
    input  logic                      mode_fn,
    input  logic [1:0]                rnd_mode,
    input  logic [NUM_OPS*WORD_W-1:0] ops_in,
    input  logic                      fused_in,
    input  logic [WORD_W-1:0]         prod_in,
    input  logic [WORD_W-1:0]         result_in,
    output logic                      out_valid,
    output logic [NUM_OPS*WORD_W-1:0] ops_out,
    output logic [WORD_W-1:0]         prod_out,
    output logic [WORD_W-1:0]         result_out,
    output logic                      flag_underflow,
    output logic                      flag_inexact,
    output logic                      unimpl,
    output logic                      sticky_e
);
    localparam logic [WORD_W-2:0] MIN_MAG = {{(EXP_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

    logic                      flush_ops;
    logic [NUM_OPS*WORD_W-1:0] ops_c;
    logic [NUM_OPS-1:0]        op_unimpl;
    logic [WORD_W-1:0]         prod_c;
    logic                      prod_unimpl;
    logic [WORD_W-1:0]         res_c;
    logic                      res_subst;
    logic                      res_unimpl;
    logic                      unimpl_c;

    // Operand flushing is enabled by either of the two flush bits.
    always_comb flush_ops = mode_fs | mode_fo;

    // One flush stage per operand.
    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        dnf_operand_flush #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_op (
            .value_i  (ops_in[k*WORD_W +: WORD_W]),
            .active_i (1'b1),
            .flush_i  (flush_ops),
            .value_o  (ops_c[k*WORD_W +: WORD_W]),
            .unimpl_o (op_unimpl[k])
        );
    end

    // The fused intermediate is flushed only by mode_fs.
    dnf_operand_flush #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_prod (
        .value_i  (prod_in),
        .active_i (fused_in),
        .flush_i  (mode_fs),
        .value_o  (prod_c),
        .unimpl_o (prod_unimpl)
    );

    dnf_result_subst #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_res (
        .value_i   (result_in),
        .flush_i   (flush_ops),
        .nearest_i (mode_fn),
        .rnd_i     (dnf_pkg::rnd_e'(rnd_mode)),
        .value_o   (res_c),
        .subst_o   (res_subst),
        .unimpl_o  (res_unimpl)
    );

    // Combine every unimplemented source of the operation.
    always_comb unimpl_c = (|op_unimpl) | prod_unimpl | res_unimpl;

    // Output register: data held between operations, flags pulse with out_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            ops_out        <= '0;
            prod_out       <= '0;
            result_out     <= '0;
            flag_underflow <= 1'b0;
            flag_inexact   <= 1'b0;
            unimpl         <= 1'b0;
            sticky_e       <= 1'b0;
        end else begin
            out_valid      <= in_valid;
            flag_underflow <= in_valid & res_subst;
            flag_inexact   <= in_valid & res_subst;
            unimpl         <= in_valid & unimpl_c;
            if (in_valid) begin
                ops_out    <= ops_c;
                prod_out   <= prod_c;
                result_out <= res_c;
                sticky_e   <= unimpl_c;
            end
        end
    end

    // One out_valid pulse per accepted operation, none otherwise.
    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !flag_underflow && !unimpl);
    // Data and the sticky bit hold while idle.
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result_out) && $stable(ops_out) && $stable(sticky_e));
    // With every mode bit clear nothing is rewritten.
    assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_fs && !mode_fo && !mode_fn) |=>
        (result_out == $past(result_in)) && (ops_out == $past(ops_in)) && !flag_underflow);
    // Sticky status mirrors the indication of the operation just completed.
    assert_sticky_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (sticky_e == unimpl));
    // A substituted result is a signed zero or signed smallest normal, both flags set.
    assert_subst_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_underflow |-> flag_inexact &&
        ((result_out[WORD_W-2:0] == '0) || (result_out[WORD_W-2:0] == MIN_MAG)));
    // The result sign always survives.
    assert_sign_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result_out[WORD_W-1] == $past(result_in[WORD_W-1]));
endmodule

// File: tb/sim_dnf_unit.sv
`timescale 1ns/1ps
module sim_dnf_unit;
    localparam logic [31:0] ONE  = 32'h3F800000;
    localparam logic [31:0] INF  = 32'h7F800000;
    localparam logic [31:0] QNAN = 32'h7FC00000;
    localparam logic [31:0] PZ   = 32'h00000000;
    localparam logic [31:0] NZ   = 32'h80000000;
    localparam logic [31:0] PMIN = 32'h00800000;
    localparam logic [31:0] NMIN = 32'h80800000;

    typedef struct packed {
        logic        fs, fo, fn;
        logic [1:0]  rnd;
        logic        fused;
        logic [31:0] a, b, c, p, r;
        logic [31:0] ea, eb, ec, ep, er;
        logic        uf, un;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        // fs fo fn rnd fused  a  b  c  p  r  |  ea eb ec ep er  uf un
        '{1'b0,1'b0,1'b0,2'd0,1'b0, ONE,INF,QNAN,32'h00000001,NZ,  ONE,INF,QNAN,32'h00000001,NZ, 1'b0,1'b0},
        '{1'b0,1'b0,1'b0,2'd0,1'b0, 32'h00000001,ONE,PZ,PZ,ONE,    32'h00000001,ONE,PZ,PZ,ONE,   1'b0,1'b1},
        '{1'b0,1'b0,1'b0,2'd2,1'b0, ONE,ONE,ONE,PZ,32'h80200000,   ONE,ONE,ONE,PZ,32'h80200000,  1'b0,1'b1},
        '{1'b0,1'b1,1'b0,2'd0,1'b0, 32'h00000001,32'h80000005,ONE,PZ,ONE, PZ,NZ,ONE,PZ,ONE,      1'b0,1'b0},
        '{1'b0,1'b1,1'b0,2'd0,1'b1, ONE,ONE,ONE,32'h80000010,ONE,  ONE,ONE,ONE,32'h80000010,ONE, 1'b0,1'b1},
        '{1'b1,1'b0,1'b0,2'd0,1'b1, ONE,ONE,ONE,32'h80000010,ONE,  ONE,ONE,ONE,NZ,ONE,           1'b0,1'b0},
        '{1'b0,1'b0,1'b1,2'd0,1'b0, ONE,ONE,ONE,PZ,32'h00400000,   ONE,ONE,ONE,PZ,PMIN,          1'b1,1'b0},
        '{1'b0,1'b0,1'b1,2'd2,1'b0, ONE,ONE,ONE,PZ,32'h80200000,   ONE,ONE,ONE,PZ,NZ,            1'b1,1'b0},
        '{1'b0,1'b0,1'b1,2'd0,1'b0, ONE,ONE,ONE,PZ,32'h003FFFFF,   ONE,ONE,ONE,PZ,PZ,            1'b1,1'b0},
        '{1'b0,1'b0,1'b1,2'd0,1'b0, 32'h00000001,ONE,ONE,PZ,32'h80400001, 32'h00000001,ONE,ONE,PZ,NMIN, 1'b1,1'b1},
        '{1'b1,1'b0,1'b0,2'd2,1'b0, ONE,ONE,ONE,PZ,32'h00000001,   ONE,ONE,ONE,PZ,PMIN,          1'b1,1'b0},
        '{1'b1,1'b0,1'b0,2'd2,1'b0, ONE,ONE,ONE,PZ,32'h80000001,   ONE,ONE,ONE,PZ,NZ,            1'b1,1'b0},
        '{1'b0,1'b1,1'b0,2'd3,1'b0, ONE,ONE,ONE,PZ,32'h80000001,   ONE,ONE,ONE,PZ,NMIN,          1'b1,1'b0},
        '{1'b0,1'b1,1'b0,2'd3,1'b0, ONE,ONE,ONE,PZ,32'h007FFFFF,   ONE,ONE,ONE,PZ,PZ,            1'b1,1'b0},
        '{1'b1,1'b1,1'b0,2'd1,1'b0, ONE,ONE,ONE,PZ,32'h807FFFFF,   ONE,ONE,ONE,PZ,NZ,            1'b1,1'b0},
        '{1'b1,1'b1,1'b1,2'd0,1'b1, NZ,INF,ONE,QNAN,INF,           NZ,INF,ONE,QNAN,INF,          1'b0,1'b0}
    };
    localparam string TAG [NV] = '{"R1/R4", "R2", "R2", "R3", "R4", "R4", "R5", "R5",
                                   "R5", "R5/R7", "R6", "R6", "R6", "R6", "R6", "R1"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode_fs = 1'b0, mode_fo = 1'b0, mode_fn = 1'b0;
    logic [1:0]  rnd_mode = 2'd0;
    logic [95:0] ops_in = '0;
    logic        fused_in = 1'b0;
    logic [31:0] prod_in = '0, result_in = '0;
    logic        out_valid;
    logic [95:0] ops_out;
    logic [31:0] prod_out, result_out;
    logic        flag_underflow, flag_inexact, unimpl, sticky_e;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    dnf_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .mode_fs(mode_fs), .mode_fo(mode_fo), .mode_fn(mode_fn), .rnd_mode(rnd_mode),
        .ops_in(ops_in), .fused_in(fused_in), .prod_in(prod_in), .result_in(result_in),
        .out_valid(out_valid), .ops_out(ops_out), .prod_out(prod_out), .result_out(result_out),
        .flag_underflow(flag_underflow), .flag_inexact(flag_inexact),
        .unimpl(unimpl), .sticky_e(sticky_e)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Present one operation at a falling edge; outputs are sampled one edge later.
    task automatic apply(input vec_t v);
        @(negedge clk);
        mode_fs = v.fs; mode_fo = v.fo; mode_fn = v.fn; rnd_mode = v.rnd;
        fused_in = v.fused; ops_in = {v.c, v.b, v.a}; prod_in = v.p; result_in = v.r;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "out_valid", {31'd0, out_valid}, 32'd0);
        chk("R10", "result_out", result_out, 32'd0);
        chk("R10", "sticky_e", {31'd0, sticky_e}, 32'd0);
        chk("R10", "flags", {29'd0, flag_underflow, flag_inexact, unimpl}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            chk(TAG[i], "out_valid (R9)", {31'd0, out_valid}, 32'd1);
            chk(TAG[i], "result_out", result_out, VEC[i].er);
            chk(TAG[i], "op a", ops_out[31:0], VEC[i].ea);
            chk(TAG[i], "op b", ops_out[63:32], VEC[i].eb);
            chk(TAG[i], "op c", ops_out[95:64], VEC[i].ec);
            chk(TAG[i], "prod_out", prod_out, VEC[i].ep);
            chk(TAG[i], "underflow", {31'd0, flag_underflow}, {31'd0, VEC[i].uf});
            chk(TAG[i], "inexact", {31'd0, flag_inexact}, {31'd0, VEC[i].uf});
            chk(TAG[i], "unimpl", {31'd0, unimpl}, {31'd0, VEC[i].un});
            chk(TAG[i], "sticky_e", {31'd0, sticky_e}, {31'd0, VEC[i].un});
        end

        // R9 and R8: raise unimpl, then idle; data and sticky hold, pulses drop.
        apply(VEC[1]);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9", "idle out_valid", {31'd0, out_valid}, 32'd0);
            chk("R9", "idle unimpl pulse", {31'd0, unimpl}, 32'd0);
            chk("R9", "idle result hold", result_out, ONE);
            chk("R8", "idle sticky hold", {31'd0, sticky_e}, 32'd1);
        end
        // R8: a clean operation clears the sticky bit.
        apply(VEC[3]);
        chk("R8", "sticky cleared", {31'd0, sticky_e}, 32'd0);
        // R9: flags pulse for one cycle only.
        apply(VEC[10]);
        chk("R7", "underflow pulse", {31'd0, flag_underflow}, 32'd1);
        @(negedge clk);
        chk("R9", "underflow after pulse", {31'd0, flag_underflow}, 32'd0);
        chk("R9", "result held", result_out, PMIN);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule